// File: doc/BRIEF.md
# Rate-Adjustable Adder-Based Time Base

This block keeps local time as a binary seconds-plus-fraction word, in the style of network time. It does not count oscillator ticks one by one. On every tick it adds a programmable step to an accumulator whose low end extends below the fraction LSB. The rate of the clock is therefore set by the step value alone. With the default widths, one step LSB at a 50 MHz tick corresponds to a rate change of about 4.3e-11 s/s, which is finer than 1e-10 s/s.

Software initialises the clock by loading any time value directly. It sets the nominal rate by writing a new step. During operation, state corrections are applied by amortization rather than by a jump. A signed offset is added to the base step for a given number of ticks, and the step then returns to the base value. The time output therefore moves only forward and never jumps. A command that would give a zero or negative effective step is refused. The algorithm that computes the corrections lies outside the block.

Top module: `adder_clock`

## Requirements
- R1: After reset, `time_now` is 0, `amort_busy` is 0, and the base step equals the parameter RESET_STEP.
- R2: In a cycle with `tick` high and no load, the internal accumulator (`time_now` followed by EXT_W extra fraction bits) increases by the effective step, modulo 2^(TIME_W+EXT_W). `time_now` is the top TIME_W bits of the accumulator: seconds in the upper SEC_W bits and fraction in the lower FRAC_W bits. With no tick and no load, `time_now` holds its value.
- R3: An accepted step write changes the base step from the next cycle onward. A tick in the same cycle as the write still uses the old step.
- R4: A step write with value 0 is ignored, and the rate stays unchanged.
- R5: `load_en` sets the accumulator to `load_time` with the extra fraction bits cleared. A tick in the same cycle is discarded.
- R6: A load cancels any amortization in progress. `amort_busy` is low in the next cycle, and later ticks use the base step. An amortization request in the same cycle as a load is ignored.
- R7: An accepted amortization request (`amort_req`, signed `amort_ofs`, count `amort_ticks`) sets `amort_busy` in the next cycle. The next `amort_ticks` ticks each add base+offset. `amort_busy` clears after the last of those ticks, and later ticks add the base step.
- R8: An amortization request is refused, and `amort_busy` stays as it was, when `amort_ticks` is 0 or when base+offset is not in the range 1 to 2^STEP_W-1.
- R9: During an amortization, a step write is refused when the new step plus the active offset is not in the range 1 to 2^STEP_W-1.
- R10: A request that is accepted while `amort_busy` is high replaces the active offset and count.
- R11: Without a load, `time_now` never decreases, except when the seconds field wraps from its maximum to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oscillator tick enable; one step is added per tick |
| load_en | input | 1 | Load `load_time` into the clock |
| load_time | input | TIME_W (64) | Time value to load |
| step_wr | input | 1 | Write a new base step |
| step_val | input | STEP_W (40) | New base step in units of 2^-(FRAC_W+EXT_W) s |
| amort_req | input | 1 | Start an amortization |
| amort_ofs | input | OFS_W (32) | Signed offset added to the step during amortization |
| amort_ticks | input | CNT_W (32) | Number of ticks the offset applies to |
| time_now | output | TIME_W (64) | Current time, seconds above fraction |
| amort_busy | output | 1 | An amortization is in progress |

## Verification
Every command and tick presented in a cycle becomes visible on `time_now` and `amort_busy` exactly one rising edge later. No result arrives later than that, because both outputs come straight from registers. For each cycle it drives, the driver pushes the expected time and busy values onto a queue. The monitor pops one entry 5 ns after each following rising edge, so every comparison lands in the first cycle after its cause. Same-cycle collisions (a step write with a tick, a load with a tick, a load with a request) are driven on purpose to pin down which value that edge must show.

// File: rtl/adclk_pkg.sv
package adclk_pkg;

    typedef enum logic [0:0] {
        MODE_BASE  = 1'b0,
        MODE_AMORT = 1'b1
    } rate_mode_e;

    typedef struct packed {
        logic load;
        logic step;
        logic amort;
    } cmd_grant_t;

endpackage

// File: rtl/adclk_cmd_arb.sv
module adclk_cmd_arb
    import adclk_pkg::*;
#(
    parameter int STEP_W = 40,
    parameter int OFS_W  = 32,
    parameter int CNT_W  = 32
) (
    input  logic              load_en,
    input  logic              step_wr,
    input  logic [STEP_W-1:0] step_val,
    input  logic              amort_req,
    input  logic [OFS_W-1:0]  amort_ofs,
    input  logic [CNT_W-1:0]  amort_ticks,
    input  logic [STEP_W-1:0] base_q,
    input  logic [OFS_W-1:0]  ofs_q,
    input  rate_mode_e        mode_q,
    output cmd_grant_t        grant
);

    localparam int SUM_W = STEP_W + 2;

    // True when base + signed offset is strictly positive and still fits STEP_W bits.
    function automatic logic sum_ok(input logic [STEP_W-1:0] b, input logic [OFS_W-1:0] o);
        logic [SUM_W-1:0] s;
        s = {2'b00, b} + {{(SUM_W-OFS_W){o[OFS_W-1]}}, o};
        return (s[SUM_W-1:STEP_W] == 2'b00) && (s != '0);
    endfunction

    logic              amort_live;
    logic [STEP_W-1:0] base_next;

    always_comb begin
        grant       = '0;
        grant.load  = load_en;
        // A load in the same cycle ends the amortization, so its offset no longer constrains the write.
        amort_live  = (mode_q == MODE_AMORT) && !load_en;
        grant.step  = step_wr && (step_val != '0) &&
                      (!amort_live || sum_ok(step_val, ofs_q));
        base_next   = grant.step ? step_val : base_q;
        grant.amort = amort_req && !load_en && (amort_ticks != '0) &&
                      sum_ok(base_next, amort_ofs);
    end

endmodule

// File: rtl/adclk_rate_ctl.sv
module adclk_rate_ctl
    import adclk_pkg::*;
#(
    parameter int          STEP_W     = 40,
    parameter int          OFS_W      = 32,
    parameter int          CNT_W      = 32,
    parameter longint unsigned RESET_STEP = 64'd23058430092
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  cmd_grant_t        grant,
    input  logic [STEP_W-1:0] step_val,
    input  logic [OFS_W-1:0]  amort_ofs,
    input  logic [CNT_W-1:0]  amort_ticks,
    output logic [STEP_W-1:0] base_q,
    output logic [OFS_W-1:0]  ofs_q,
    output rate_mode_e        mode_q,
    output logic [STEP_W-1:0] eff_step
);

    localparam int EXT_OFS = STEP_W - OFS_W;

    typedef struct packed {
        logic [STEP_W-1:0] base;
        logic [OFS_W-1:0]  ofs;
        logic [CNT_W-1:0]  cnt;
        rate_mode_e        mode;
    } rate_t;

    rate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (grant.step) begin
            st_d.base = step_val;
        end
        if (tick && (st_q.mode == MODE_AMORT)) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == {{(CNT_W-1){1'b0}}, 1'b1}) begin
                st_d.mode = MODE_BASE;
            end
        end
        if (grant.amort) begin
            st_d.ofs  = amort_ofs;
            st_d.cnt  = amort_ticks;
            st_d.mode = MODE_AMORT;
        end
        if (grant.load) begin
            st_d.cnt  = '0;
            st_d.mode = MODE_BASE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.base <= STEP_W'(RESET_STEP);
            st_q.ofs  <= '0;
            st_q.cnt  <= '0;
            st_q.mode <= MODE_BASE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.mode == MODE_AMORT) begin
            eff_step = st_q.base + {{EXT_OFS{st_q.ofs[OFS_W-1]}}, st_q.ofs};
        end else begin
            eff_step = st_q.base;
        end
    end

    assign base_q = st_q.base;
    assign ofs_q  = st_q.ofs;
    assign mode_q = st_q.mode;

endmodule

// File: rtl/adclk_accum.sv
module adclk_accum #(
    parameter int TIME_W = 64,
    parameter int EXT_W  = 28,
    parameter int STEP_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_en,
    input  logic [TIME_W-1:0] load_time,
    input  logic [STEP_W-1:0] eff_step,
    output logic [TIME_W-1:0] time_now
);

    localparam int ACC_W = TIME_W + EXT_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_t;

    acc_t             ac_d, ac_q;
    logic [ACC_W-1:0] load_word;
    logic [ACC_W-1:0] step_word;

    generate
        if (EXT_W > 0) begin : g_ext
            assign load_word = {load_time, {EXT_W{1'b0}}};
        end else begin : g_noext
            assign load_word = load_time;
        end
        if (ACC_W > STEP_W) begin : g_pad
            assign step_word = {{(ACC_W-STEP_W){1'b0}}, eff_step};
        end else begin : g_nopad
            assign step_word = eff_step[ACC_W-1:0];
        end
    endgenerate

    always_comb begin
        ac_d = ac_q;
        if (load_en) begin
            ac_d.acc = load_word;
        end else if (tick) begin
            ac_d.acc = ac_q.acc + step_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac_q.acc <= '0;
        end else begin
            ac_q <= ac_d;
        end
    end

    assign time_now = ac_q.acc[ACC_W-1 -: TIME_W];

endmodule

// File: rtl/adder_clock.sv
module adder_clock
    import adclk_pkg::*;
#(
    parameter int              SEC_W      = 32,
    parameter int              FRAC_W     = 32,
    parameter int              EXT_W      = 28,
    parameter int              STEP_W     = 40,
    parameter int              OFS_W      = 32,
    parameter int              CNT_W      = 32,
    parameter longint unsigned RESET_STEP = 64'd23058430092,
    localparam int             TIME_W     = SEC_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_en,
    input  logic [TIME_W-1:0] load_time,
    input  logic              step_wr,
    input  logic [STEP_W-1:0] step_val,
    input  logic              amort_req,
    input  logic [OFS_W-1:0]  amort_ofs,
    input  logic [CNT_W-1:0]  amort_ticks,
    output logic [TIME_W-1:0] time_now,
    output logic              amort_busy
);

    cmd_grant_t        grant;
    logic [STEP_W-1:0] base_q;
    logic [OFS_W-1:0]  ofs_q;
    rate_mode_e        mode_q;
    logic [STEP_W-1:0] eff_step;

    adclk_cmd_arb #(
        .STEP_W(STEP_W), .OFS_W(OFS_W), .CNT_W(CNT_W)
    ) u_arb (
        .load_en    (load_en),
        .step_wr    (step_wr),
        .step_val   (step_val),
        .amort_req  (amort_req),
        .amort_ofs  (amort_ofs),
        .amort_ticks(amort_ticks),
        .base_q     (base_q),
        .ofs_q      (ofs_q),
        .mode_q     (mode_q),
        .grant      (grant)
    );

    adclk_rate_ctl #(
        .STEP_W(STEP_W), .OFS_W(OFS_W), .CNT_W(CNT_W), .RESET_STEP(RESET_STEP)
    ) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .grant      (grant),
        .step_val   (step_val),
        .amort_ofs  (amort_ofs),
        .amort_ticks(amort_ticks),
        .base_q     (base_q),
        .ofs_q      (ofs_q),
        .mode_q     (mode_q),
        .eff_step   (eff_step)
    );

    adclk_accum #(
        .TIME_W(TIME_W), .EXT_W(EXT_W), .STEP_W(STEP_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load_en  (load_en),
        .load_time(load_time),
        .eff_step (eff_step),
        .time_now (time_now)
    );

    assign amort_busy = (mode_q == MODE_AMORT);

endmodule

// File: rtl/adclk_chk.sv
module adclk_chk #(
    parameter int TIME_W = 64,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              load_en,
    input logic [TIME_W-1:0] load_time,
    input logic              amort_req,
    input logic [CNT_W-1:0]  amort_ticks,
    input logic [TIME_W-1:0] time_now,
    input logic              amort_busy
);

    // R1: outputs idle when reset is released
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (time_now == '0) && !amort_busy);

    // R2: no tick and no load keeps time still
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> $stable(time_now));

    // R5: load value appears on the next cycle
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (time_now == $past(load_time)));

    // R6: load ends amortization
    a_r6_load_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !amort_busy);

    // R7: amortization only ends on a tick or a load
    a_r7_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(amort_busy) |-> $past(tick || load_en));

    // R8: zero-length request never starts amortization
    a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (amort_req && (amort_ticks == '0) && !amort_busy) |=> !amort_busy);

    // R11: monotonic apart from seconds wrap
    a_r11_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en) |=> (time_now >= $past(time_now)) ||
                               ($past(time_now[TIME_W-1]) && !time_now[TIME_W-1]));

endmodule

bind adder_clock adclk_chk #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_adder_clock.sv
module sim_adder_clock;

    localparam longint unsigned RST_STEP = 64'd23058430092;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        load_en = 1'b0;
    logic [63:0] load_time = '0;
    logic        step_wr = 1'b0;
    logic [39:0] step_val = '0;
    logic        amort_req = 1'b0;
    logic [31:0] amort_ofs = '0;
    logic [31:0] amort_ticks = '0;
    logic [63:0] time_now;
    logic        amort_busy;

    always #10 clk = ~clk;

    adder_clock u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(load_en), .load_time(load_time),
        .step_wr(step_wr), .step_val(step_val), .amort_req(amort_req), .amort_ofs(amort_ofs),
        .amort_ticks(amort_ticks), .time_now(time_now), .amort_busy(amort_busy)
    );

    typedef struct {
        logic [63:0] t;
        logic        b;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;

    // reference state, built from the requirements
    logic [91:0] m_acc = '0;
    logic [39:0] m_base = 40'(RST_STEP);
    logic [31:0] m_off = '0;
    logic [31:0] m_cnt = '0;
    logic        m_busy = 1'b0;

    function automatic bit sum_ok(logic [39:0] b, logic [31:0] o);
        longint s;
        s = longint'({24'b0, b}) + longint'($signed(o));
        return (s > 0) && (s < (64'sd1 <<< 40));
    endfunction

    task automatic drive(input logic ld, input logic [63:0] lt, input logic sw,
                         input logic [39:0] sv, input logic ar, input logic [31:0] ao,
                         input logic [31:0] at, input logic tk, input string tag);
        bit          ok_step, ok_am;
        logic [39:0] nb, eff;
        exp_t        e;
        @(negedge clk);
        load_en = ld; load_time = lt; step_wr = sw; step_val = sv;
        amort_req = ar; amort_ofs = ao; amort_ticks = at; tick = tk;
        ok_step = sw && (sv != 0) && (!(m_busy && !ld) || sum_ok(sv, m_off));
        nb      = ok_step ? sv : m_base;
        ok_am   = ar && !ld && (at != 0) && sum_ok(nb, ao);
        eff     = m_busy ? m_base + {{8{m_off[31]}}, m_off} : m_base;
        if (ld) m_acc = {lt, 28'b0};
        else if (tk) m_acc = m_acc + {52'b0, eff};
        if (tk && m_busy) begin
            if (m_cnt == 1) m_busy = 1'b0;
            m_cnt = m_cnt - 1;
        end
        if (ok_am) begin m_off = ao; m_cnt = at; m_busy = 1'b1; end
        if (ld) begin m_busy = 1'b0; m_cnt = 0; end
        m_base = nb;
        e.t = m_acc[91:28]; e.b = m_busy; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic t_idle(input string tag);
        drive(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic t_tick(input int n, input string tag);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 1, tag);
    endtask
    task automatic t_load(input logic [63:0] v, input logic tk, input string tag);
        drive(1, v, 0, 0, 0, 0, 0, tk, tag);
    endtask
    task automatic t_step(input logic [39:0] v, input logic tk, input string tag);
        drive(0, 0, 1, v, 0, 0, 0, tk, tag);
    endtask
    task automatic t_amort(input logic [31:0] o, input logic [31:0] n, input logic tk,
                           input string tag);
        drive(0, 0, 0, 0, 1, o, n, tk, tag);
    endtask

    // monitor: one comparison per driven cycle, after the following rising edge
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            cur = q.pop_front();
            n_vec++;
            if (time_now !== cur.t || amort_busy !== cur.b) begin
                n_bad++;
                $display("FAIL %s: time=%h busy=%0b expected time=%h busy=%0b",
                         cur.tag, time_now, amort_busy, cur.t, cur.b);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_idle("R1 reset state");
        t_tick(6, "R2 ticks with reset step");
        t_idle("R2 hold");
        t_idle("R2 hold");
        t_load(64'h0000_0010_8000_0000, 1'b1, "R5 load wins over tick");
        t_tick(2, "R5 ticks after load");
        t_step(40'h01_0000_0000, 1'b1, "R3 tick uses old step");
        t_tick(3, "R3 new step");
        t_step(40'h0, 1'b1, "R4 zero step ignored");
        t_tick(2, "R4 rate unchanged");
        t_amort(32'h4000_0000, 32'd3, 1'b0, "R7 request");
        t_idle("R7 busy before ticks");
        t_tick(2, "R7 amortized ticks");
        t_idle("R7 still busy");
        t_tick(1, "R7 last amortized tick");
        t_tick(2, "R7 back to base step");
        t_amort(32'h1234, 32'd0, 1'b1, "R8 zero count refused");
        t_tick(1, "R8 rate unchanged");
        t_step(40'd1000, 1'b0, "R3 small step");
        t_amort(-32'sd1000, 32'd4, 1'b1, "R8 zero sum refused");
        t_amort(-32'sd2000, 32'd4, 1'b1, "R8 negative sum refused");
        t_tick(2, "R8 rate unchanged");
        t_step(40'h01_0000_0000, 1'b0, "R3 restore step");
        t_amort(32'h8000_0000, 32'd5, 1'b1, "R7 negative offset request");
        t_tick(1, "R7 slowed tick");
        t_step(40'h00_4000_0000, 1'b1, "R9 step under offset refused");
        t_tick(1, "R9 rate unchanged");
        t_step(40'h02_0000_0000, 1'b1, "R9 valid step during amortization");
        t_tick(1, "R9 new base with offset");
        t_amort(32'h0000_0100, 32'd2, 1'b1, "R10 replace while busy");
        t_tick(3, "R10 replaced offset then base");
        t_amort(32'h1000_0000, 32'd50, 1'b1, "R6 long amortization");
        t_tick(2, "R6 amortizing");
        drive(1, 64'h0000_0100_0000_0000, 0, 0, 1, 32'h10, 32'd9, 1, "R6 load cancels and ignores request");
        t_tick(3, "R6 base step after load");
        t_load(64'hFFFF_FFFF_FFFF_FFF0, 1'b0, "R2 load near wrap");
        t_tick(4, "R11 seconds wrap");
        for (int k = 0; k < 300; k++) begin
            if (k % 37 == 5) t_amort(32'(k * 977), 32'(k % 7), (k % 2) == 0, "R7 mixed pattern");
            else if (k % 53 == 11) t_step(40'h01_0000_0000 + 40'(k), 1'b1, "R3 mixed pattern");
            else drive(0, 0, 0, 0, 0, 0, 0, (k % 3) != 1, "R11 mixed pattern");
        end
        t_idle("R2 final hold");
        t_idle("R2 final hold");
        @(posedge clk);
        @(posedge clk);
        #8;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule